// File: doc/BRIEF.md
# Interrupt Countdown Timer

A per-core timer that counts down a programmed value and raises an interrupt request when it expires. Software programs it through a small register bus: an initial count, a read-only current count, a prescaler selection and a timer entry. The timer entry holds the vector, a mask bit and a mode field. In one-shot mode the count runs down once. In periodic mode the count reloads each time it expires. In deadline mode a 64-bit deadline is compared against a free-running timestamp input and clears itself when it fires.

The mode can be changed while the count is running. The current count keeps its value through the change, and the stored initial count is never touched by it. Each expiry produces one single-cycle request on `irq_o`, and the programmed vector is presented alongside it on `irq_vec_o`. Prioritisation and delivery of that request are left to the logic that consumes it.

Top module: `loc_tmr`

## Requirements
- R1: Register addresses are: 0 timer entry, 1 initial count, 2 current count (read-only), 3 prescaler selection, 4 deadline. Timer entry fields are vector in bits 7:0, mask in bit 16, and mode in bits 18:17 (00 one-shot, 01 periodic, 10 deadline, 11 behaves as one-shot). After reset the entry reads 0x10000 (masked, one-shot, vector 0), all counts and the deadline read 0, and `irq_o` is low.
- R2: A write to the initial count loads the current count with the written value in the cycle after the write edge, and restarts the prescaler. From then on, each prescaler tick lowers the current count by one.
- R3: Prescaler selection bits {3,1,0} form a 3-bit index. Index 7 (for example the value 0xB) divides the clock by 1. Any other index k divides by 2^(k+1); for example the value 0x1 divides by 4.
- R4: In one-shot mode, after an initial count N with divide D, `irq_o` is high exactly N*D cycles after the write edge. The current count then holds at 0, and no further request follows.
- R5: In periodic mode, the tick that would take the count from 1 to 0 instead reloads the initial count, and it raises a request. Requests therefore repeat every N*D cycles.
- R6: Writing the mode field (one-shot or periodic) neither reloads nor resets the current count. Counting continues from its present value, and the initial count reads unchanged.
- R7: If the current count is 0 when the mode is switched to periodic, it stays 0 and no request is raised.
- R8: Writing an initial count of 0 stops the timer: the current count reads 0 and no request follows.
- R9: With the mask bit set, expiries raise no request, but the count still runs down.
- R10: In deadline mode, a nonzero deadline D fires in the cycle after the first cycle in which the timestamp input is at least D. A deadline that is already past therefore fires one cycle after it is written. The deadline register reads 0 after firing. In this mode the current count does not move.
- R11: Every request is a one-cycle pulse on `irq_o`, with the entry's vector on `irq_vec_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 64 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 64 | Read data, combinational from rd_addr_i |
| tsc_i | input | 64 | Free-running timestamp for deadline mode |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector accompanying irq_o |

## Verification
The bench targets the cycle of each expiry under divide-by-1 and divide-by-4. A prescaler that is off by one, or that is not restarted by an initial-count write, moves every request by whole cycles. Mid-count switches in both directions check that a design does not reload the current count or clobber the initial count on a mode write. Such a design would fire late or read back 20 where 10 is expected. A zero count switched to periodic catches a design that reloads from zero and fires spuriously. Past and future deadlines check both the firing cycle and self-clearing: a design that leaves the deadline armed would read it back nonzero or fire repeatedly.

// File: rtl/loc_tmr_pkg.sv
package loc_tmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONE = 2'b00,
    MODE_PER = 2'b01,
    MODE_DL  = 2'b10,
    MODE_RSV = 2'b11
  } tmr_mode_e;

  localparam logic [2:0] A_ENTRY = 3'd0;
  localparam logic [2:0] A_INIT  = 3'd1;
  localparam logic [2:0] A_CUR   = 3'd2;
  localparam logic [2:0] A_DIV   = 3'd3;
  localparam logic [2:0] A_DL    = 3'd4;

  localparam int unsigned VEC_LSB  = 0;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned MODE_LSB = 17;

  typedef struct packed {
    tmr_mode_e   mode;
    logic        mask;
    logic [7:0]  vec;
  } tmr_entry_t;
endpackage

// File: rtl/loc_tmr_regs.sv
module loc_tmr_regs
  import loc_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output tmr_entry_t        entry_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [3:0]        div_cfg_o,
  output logic              ld_o,
  output logic              dl_wr_o
);
  tmr_entry_t       entry_q;
  logic [CNT_W-1:0] init_q;
  logic [3:0]       div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '{mode: MODE_ONE, mask: 1'b1, vec: 8'h00};
      init_q  <= '0;
      div_q   <= 4'h0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_ENTRY: begin
          entry_q.vec  <= wr_data_i[VEC_LSB +: 8];
          entry_q.mask <= wr_data_i[MASK_BIT];
          entry_q.mode <= tmr_mode_e'(wr_data_i[MODE_LSB +: 2]);
        end
        A_INIT:  init_q <= wr_data_i[CNT_W-1:0];
        A_DIV:   div_q  <= wr_data_i[3:0];
        default: ;
      endcase
    end
  end

  assign entry_o   = entry_q;
  assign init_o    = init_q;
  assign div_cfg_o = div_q;
  assign ld_o      = wr_en_i && (wr_addr_i == A_INIT);
  assign dl_wr_o   = wr_en_i && (wr_addr_i == A_DL);
endmodule

// File: rtl/loc_tmr_presc.sv
module loc_tmr_presc #(
  parameter int unsigned PW = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] div_cfg_i,
  input  logic       clr_i,
  output logic       tick_o
);
  logic [2:0]    idx;
  logic [PW-1:0] div_m1;
  logic [PW-1:0] cnt_q;

  assign idx    = {div_cfg_i[3], div_cfg_i[1:0]};
  assign div_m1 = (idx == 3'd7) ? '0 : PW'((32'd2 << idx) - 32'd1);
  // >= so a smaller divide chosen mid-run cannot strand the counter
  assign tick_o = !clr_i && (cnt_q >= div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < div_m1 && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/loc_tmr_count.sv
module loc_tmr_count
  import loc_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  tmr_mode_e        mode_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;
  logic             run;
  logic             last;

  assign run      = (mode_i != MODE_DL);
  assign last     = (cur_q == CNT_W'(1));
  assign expire_o = !ld_i && tick_i && run && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (ld_i) begin
      cur_q <= ld_val_i;
    end else if (tick_i && run && cur_q != '0) begin
      if (last) cur_q <= (mode_i == MODE_PER) ? init_i : '0;
      else      cur_q <= cur_q - 1'b1;
    end
  end

  assign cur_o = cur_q;

  // R4
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == '0 && !ld_i) |=> (cur_q == '0));
  // R2
  count_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && tick_i && run && cur_q > CNT_W'(1)) |=> (cur_q == $past(cur_q) - 1'b1));
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && tick_i && mode_i == MODE_PER && last) |=> (cur_q == $past(init_i)));
  // R10
  dl_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && mode_i == MODE_DL) |=> $stable(cur_q));
endmodule

// File: rtl/loc_tmr_dl.sv
module loc_tmr_dl #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [TS_W-1:0] wr_val_i,
  input  logic [TS_W-1:0] tsc_i,
  input  logic            armed_i,
  output logic [TS_W-1:0] dl_o,
  output logic            expire_o
);
  logic [TS_W-1:0] dl_q;

  // a write in the same cycle wins over a hit
  assign expire_o = armed_i && !wr_i && (dl_q != '0) && (tsc_i >= dl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dl_q <= '0;
    else if (wr_i)     dl_q <= wr_val_i;
    else if (expire_o) dl_q <= '0;
  end

  assign dl_o = dl_q;

  // R10
  dl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (dl_q == '0));
  // R10
  dl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !expire_o) |=> $stable(dl_q));
endmodule

// File: rtl/loc_tmr.sv
module loc_tmr
  import loc_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TS_W   = 64,
  parameter int unsigned PW     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [TS_W-1:0]   tsc_i,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o
);
  tmr_entry_t       entry;
  logic [CNT_W-1:0] init_cnt, cur_cnt;
  logic [3:0]       div_cfg;
  logic             ld, dl_wr, tick, cnt_exp, dl_exp;
  logic [TS_W-1:0]  dl_val;
  logic             irq_q;
  logic [7:0]       vec_q;

  loc_tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .entry_o(entry), .init_o(init_cnt), .div_cfg_o(div_cfg),
    .ld_o(ld), .dl_wr_o(dl_wr)
  );

  loc_tmr_presc #(.PW(PW)) i_presc (
    .clk_i, .rst_ni, .div_cfg_i(div_cfg), .clr_i(ld), .tick_o(tick)
  );

  loc_tmr_count #(.CNT_W(CNT_W)) i_count (
    .clk_i, .rst_ni, .tick_i(tick), .ld_i(ld),
    .ld_val_i(wr_data_i[CNT_W-1:0]), .init_i(init_cnt),
    .mode_i(entry.mode), .cur_o(cur_cnt), .expire_o(cnt_exp)
  );

  loc_tmr_dl #(.TS_W(TS_W)) i_dl (
    .clk_i, .rst_ni, .wr_i(dl_wr), .wr_val_i(wr_data_i[TS_W-1:0]),
    .tsc_i, .armed_i(entry.mode == MODE_DL), .dl_o(dl_val), .expire_o(dl_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= (cnt_exp || dl_exp) && !entry.mask;
      vec_q <= entry.vec;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_ENTRY: begin
        rd_data_o[VEC_LSB +: 8]  = entry.vec;
        rd_data_o[MASK_BIT]      = entry.mask;
        rd_data_o[MODE_LSB +: 2] = entry.mode;
      end
      A_INIT:  rd_data_o[CNT_W-1:0] = init_cnt;
      A_CUR:   rd_data_o[CNT_W-1:0] = cur_cnt;
      A_DIV:   rd_data_o[3:0]       = div_cfg;
      A_DL:    rd_data_o[TS_W-1:0]  = dl_val;
      default: rd_data_o = '0;
    endcase
  end

  // R11
  expire_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cnt_exp, dl_exp}));
  // R9
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry.mask && !(wr_en_i && wr_addr_i == A_ENTRY)) |=> !irq_o);
endmodule

// File: tb/test_loc_tmr.sv
module test_loc_tmr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [63:0] cyc = '0;
  logic        irq;
  logic [7:0]  irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { longint cyc; logic [7:0] vec; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  loc_tmr i_loc_tmr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tsc_i(cyc), .irq_o(irq), .irq_vec_o(irq_vec)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d, output longint c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c = longint'(cyc);
  endtask

  task automatic rd(input logic [2:0] a, output longint v);
    rd_addr = a;
    #1;
    v = longint'(rd_data);
  endtask

  task automatic wait_until(input longint c);
    while (longint'(cyc) < c) @(negedge clk);
  endtask

  task automatic push(input longint c, input logic [7:0] v);
    exp_t e;
    e.cyc = c; e.vec = v;
    exp_q.push_back(e);
  endtask

  task automatic drained(input string req);
    chk({req, " pending irqs"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  function automatic logic [63:0] ent(input int mode, input bit mask, input logic [7:0] vec);
    return (64'(mode) << 17) | (64'(mask) << 16) | 64'(vec);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected irq actual cyc=%0d vec=%0h expected none", cyc, irq_vec);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R11 irq cycle", longint'(cyc), e.cyc);
        chk("R11 irq vector", longint'(irq_vec), longint'(e.vec));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint c, v, k, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 entry", v, 64'h10000);
    rd(3'd1, v); chk("R1 init", v, 0);
    rd(3'd2, v); chk("R1 cur", v, 0);
    rd(3'd4, v); chk("R1 deadline", v, 0);
    chk("R1 irq", longint'(irq), 0);

    // R2/R4 one-shot divide-by-1
    wr(3'd3, 64'hB, c);
    wr(3'd0, ent(0, 0, 8'h31), c);
    wr(3'd1, 64'd5, c);
    push(c + 5, 8'h31);
    rd(3'd2, v); chk("R2 load", v, 5);
    wait_until(c + 2);
    rd(3'd2, v); chk("R2 decrement", v, 3);
    wait_until(c + 10);
    rd(3'd2, v); chk("R4 hold zero", v, 0);
    drained("R4");

    // R3 divide-by-4
    wr(3'd3, 64'h1, c);
    wr(3'd1, 64'd3, c);
    push(c + 12, 8'h31);
    wait_until(c + 5);
    rd(3'd2, v); chk("R3 div4 count", v, 2);
    wait_until(c + 14);
    rd(3'd2, v); chk("R3 div4 end", v, 0);
    drained("R3");

    // R5 periodic, then R8 stop
    wr(3'd3, 64'hB, c);
    wr(3'd0, ent(1, 0, 8'h52), c);
    wr(3'd1, 64'd4, c);
    push(c + 4, 8'h52); push(c + 8, 8'h52); push(c + 12, 8'h52);
    wait_until(c + 13);
    rd(3'd2, v); chk("R5 reload", v, 3);
    wr(3'd1, 64'd0, c);
    rd(3'd2, v); chk("R8 stopped", v, 0);
    wait_until(c + 12);
    rd(3'd2, v); chk("R8 still zero", v, 0);
    drained("R5");

    // R6 mode change mid-count
    wr(3'd0, ent(0, 0, 8'h66), c);
    wr(3'd1, 64'd20, c);
    k = c;
    wait_until(k + 8);
    rd(3'd2, v); chk("R2 count", v, 12);
    wr(3'd0, ent(1, 0, 8'h66), c);
    rd(3'd2, v); chk("R6 no reset to periodic", v, 10);
    rd(3'd1, v); chk("R6 init kept", v, 20);
    push(k + 20, 8'h66); push(k + 40, 8'h66);
    wait_until(k + 42);
    rd(3'd2, v); chk("R5 periodic reload", v, 18);
    wr(3'd0, ent(0, 0, 8'h66), c);
    rd(3'd2, v); chk("R6 no reset to one-shot", v, 16);
    rd(3'd1, v); chk("R6 init kept", v, 20);
    push(k + 60, 8'h66);
    wait_until(k + 64);
    rd(3'd2, v); chk("R4 zero after switch", v, 0);
    drained("R6");

    // R7 zero count switched to periodic
    wr(3'd0, ent(1, 0, 8'h66), c);
    wait_until(c + 30);
    rd(3'd2, v); chk("R7 stays zero", v, 0);
    drained("R7");

    // R9 masked expiry
    wr(3'd0, ent(0, 1, 8'h77), c);
    wr(3'd1, 64'd3, c);
    wait_until(c + 6);
    rd(3'd2, v); chk("R9 counter ran", v, 0);
    drained("R9");

    // R10 deadline, past value
    wr(3'd0, ent(2, 0, 8'h99), c);
    d = longint'(cyc) - 3;
    wr(3'd4, 64'(d), c);
    push(c + 1, 8'h99);
    wait_until(c + 3);
    rd(3'd4, v); chk("R10 self clear", v, 0);
    drained("R10");

    // R10 deadline, future value
    d = longint'(cyc) + 12;
    wr(3'd4, 64'(d), c);
    push(d + 1, 8'h99);
    rd(3'd4, v); chk("R10 armed", v, d);
    wait_until(d + 3);
    rd(3'd4, v); chk("R10 self clear future", v, 0);
    drained("R10");

    // R10 counter frozen in deadline mode
    wr(3'd1, 64'd7, c);
    wait_until(c + 10);
    rd(3'd2, v); chk("R10 count frozen", v, 7);
    drained("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule